// File: doc/BRIEF.md
# Dual-Integrator Conversion Sequencer

This block is the digital controller for a two-input charge-integrating front end. Each input owns two integrators, side A and side B. The block runs on the system clock and reads a synchronous conversion-control level, `conv_i`. When that level is high, both side-A integrators collect charge. When it is low, both side-B integrators do. The side that has just stopped integrating is digitised through one shared, time-multiplexed converter. Its input-1 integrator goes first and its input-2 integrator second.

For every integrator, the block produces a 2-bit switch-configuration code: reset, wait, integrate or convert. It steps the converter mux through the idle side and pulses a done strobe after each conversion. When both results for a side are complete, it pulls an active-low data-valid output low. A fixed cycle count, `CONV_CYCLES`, stands in for the delta-sigma conversion; the default of 2200 cycles is 220 µs at 10 MHz. The range code and the test-charge request are sampled on each level change and held until the next one. A level change that arrives while conversions are still running sets a sticky overrun flag.

Integrator `i` is numbered `i = 2*input + side`, where input 0 is input 1, side 0 is A and side 1 is B. Its code sits at `sw_cfg_o[2*i+1:2*i]`.

Top module: `dual_integ_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, with no change on `conv_i`, every field of `sw_cfg_o` reads 0 (reset), and `data_valid_no` is 1. `busy_o`, `done_o`, `overrun_o`, `range_o` and `test_sel_o` all read 0.
- R2: A change on `conv_i` takes effect after the second rising clock edge.
  - `side_o` then reads 0 when `conv_i` is high (A integrates) and 1 when it is low (B integrates).
  - Both integrators of the integrating side show code 2 (integrate).
- R3: During the first conversion, the non-integrating side's input-1 integrator shows code 3 (convert) and its input-2 integrator shows code 1 (wait). `mux_sel_o` equals {0, converting side}.
- R4: During the second conversion, the converting side's input-1 integrator shows code 0 (reset) and its input-2 integrator shows code 3. `mux_sel_o` equals {1, converting side}.
- R5: Each conversion lasts `CONV_CYCLES` clocks.
  - `done_o[j]` is a one-cycle pulse for input j, first bit 0 and then bit 1.
  - `busy_o` is high for exactly 2*`CONV_CYCLES` cycles from the cycle the change takes effect.
- R6: After the second conversion, `data_valid_no` goes low in the same cycle as `done_o[1]`, and both converting-side integrators return to code 0.
- R7: `data_valid_no` returns high in the cycle in which a new `conv_i` change takes effect.
- R8: `range_o` takes the value of `range_i` when a `conv_i` change takes effect. It does not follow `range_i` between changes.
- R9: When a change takes effect, `test_sel_o` is set as follows, and it is held until the next change:
  - if `test_i` is high, it is one-hot on the side that starts integrating (bit 0 = A, bit 1 = B);
  - otherwise it is 0.
- R10: A `conv_i` change that takes effect while `busy_o` is high sets `overrun_o`, which stays high until reset. Conversion then restarts for the new idle side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| conv_i | input | 1 | integration side select, synchronous |
| range_i | input | RANGE_W | full-scale range code, MSB first |
| test_i | input | 1 | test-charge request |
| sw_cfg_o | output | 4*N_IN | 2-bit switch code per integrator |
| mux_sel_o | output | $clog2(N_IN)+1 | {input index, side} of the integrator being converted |
| busy_o | output | 1 | conversion in progress |
| done_o | output | N_IN | per-input conversion done pulse |
| data_valid_no | output | 1 | results ready, active low |
| overrun_o | output | 1 | sticky early-change flag |
| side_o | output | 1 | integrating side, 0 = A |
| range_o | output | RANGE_W | captured range code |
| test_sel_o | output | 2 | test charge enable per side |

## Verification
Suppose `conv_i` changes before rising edge k. It is registered at edge k, and every result moves at edge k+1. `done_o[0]` is due `CONV_CYCLES` edges after that, and `done_o[1]` together with the fall of `data_valid_no` is due 2*`CONV_CYCLES` edges after it. The bench drives and samples on falling edges and counts the edges elapsed since edge k+1. From that count it derives, for every sample, each expected switch code, the mux select, the strobes, the data-valid level and the captured range and test values.

// File: rtl/dis_pkg.sv
package dis_pkg;
  typedef enum logic [1:0] {
    CFG_RESET = 2'd0,
    CFG_WAIT  = 2'd1,
    CFG_INTEG = 2'd2,
    CFG_CONV  = 2'd3
  } sw_cfg_e;
endpackage

// File: rtl/dis_conv_edge.sv
module dis_conv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  output logic level_o,
  output logic edge_o
);
  logic conv_q, conv_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q  <= 1'b0;
      conv_q2 <= 1'b0;
    end else begin
      conv_q  <= conv_i;
      conv_q2 <= conv_q;
    end
  end

  assign level_o = conv_q;
  assign edge_o  = conv_q ^ conv_q2;
endmodule

// File: rtl/dis_seq_core.sv
module dis_seq_core #(
  parameter int unsigned N_IN        = 2,
  parameter int unsigned CONV_CYCLES = 2200,
  localparam int unsigned IN_W  = $clog2(N_IN),
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic            level_i,
  output logic            started_o,
  output logic            int_side_o,
  output logic            conv_side_o,
  output logic            busy_o,
  output logic [IN_W-1:0] cur_in_o,
  output logic [N_IN-1:0] done_o,
  output logic            data_valid_no,
  output logic            overrun_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [IN_W-1:0]  IN_LAST  = IN_W'(N_IN - 1);

  logic            started_q, int_side_q, conv_side_q, busy_q, dv_n_q, ovr_q;
  logic [IN_W-1:0] cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N_IN-1:0] done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      int_side_q  <= 1'b0;
      conv_side_q <= 1'b0;
      busy_q      <= 1'b0;
      dv_n_q      <= 1'b1;
      ovr_q       <= 1'b0;
      cur_q       <= '0;
      cnt_q       <= '0;
      done_q      <= '0;
    end else begin
      done_q <= '0;
      if (edge_i) begin
        // high level: A integrates, B is digitised
        started_q   <= 1'b1;
        int_side_q  <= ~level_i;
        conv_side_q <= level_i;
        busy_q      <= 1'b1;
        cur_q       <= '0;
        cnt_q       <= '0;
        dv_n_q      <= 1'b1;
        if (busy_q) ovr_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q         <= '0;
          done_q[cur_q] <= 1'b1;
          if (cur_q == IN_LAST) begin
            busy_q <= 1'b0;
            dv_n_q <= 1'b0;
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign started_o     = started_q;
  assign int_side_o    = int_side_q;
  assign conv_side_o   = conv_side_q;
  assign busy_o        = busy_q;
  assign cur_in_o      = cur_q;
  assign done_o        = done_q;
  assign data_valid_no = dv_n_q;
  assign overrun_o     = ovr_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= CNT_LAST)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_q)); // R5
  AST_DV_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dv_n_q) |-> done_q[N_IN-1]); // R6
  AST_DV_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> dv_n_q); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q); // R10
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && busy_q) |=> ovr_q); // R10
endmodule

// File: rtl/dis_integ_ctrl.sv
module dis_integ_ctrl
  import dis_pkg::*;
#(
  parameter int unsigned IN_IDX = 0,
  parameter bit          SIDE   = 1'b0,
  parameter int unsigned IN_W   = 1
) (
  input  logic            started_i,
  input  logic            int_side_i,
  input  logic            busy_i,
  input  logic [IN_W-1:0] cur_in_i,
  output sw_cfg_e         cfg_o
);
  always_comb begin
    if (!started_i)                               cfg_o = CFG_RESET;
    else if (int_side_i == SIDE)                  cfg_o = CFG_INTEG;
    else if (busy_i && int'(cur_in_i) == IN_IDX)  cfg_o = CFG_CONV;
    else if (busy_i && int'(cur_in_i) < IN_IDX)   cfg_o = CFG_WAIT;
    else                                          cfg_o = CFG_RESET;
  end
endmodule

// File: rtl/dis_cfg_capture.sv
module dis_cfg_capture #(
  parameter int unsigned RANGE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_i,
  input  logic               level_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               test_i,
  output logic [RANGE_W-1:0] range_o,
  output logic [1:0]         test_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_o    <= '0;
      test_sel_o <= '0;
    end else if (edge_i) begin
      range_o    <= range_i;
      test_sel_o <= test_i ? (level_i ? 2'b01 : 2'b10) : 2'b00;
    end
  end

  AST_RANGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(range_o)); // R8
  AST_TEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(test_sel_o)); // R9
endmodule

// File: rtl/dual_integ_seq.sv
module dual_integ_seq
  import dis_pkg::*;
#(
  parameter int unsigned N_IN        = 2,
  parameter int unsigned CONV_CYCLES = 2200,
  parameter int unsigned RANGE_W     = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  conv_i,
  input  logic [RANGE_W-1:0]    range_i,
  input  logic                  test_i,
  output logic [4*N_IN-1:0]     sw_cfg_o,
  output logic [$clog2(N_IN):0] mux_sel_o,
  output logic                  busy_o,
  output logic [N_IN-1:0]       done_o,
  output logic                  data_valid_no,
  output logic                  overrun_o,
  output logic                  side_o,
  output logic [RANGE_W-1:0]    range_o,
  output logic [1:0]            test_sel_o
);
  localparam int unsigned IN_W = $clog2(N_IN);
  localparam int unsigned N_INTEG = 2 * N_IN;

  logic            level_w, edge_w, started_w, int_side_w, conv_side_w, busy_w;
  logic [IN_W-1:0] cur_in_w;
  sw_cfg_e         cfg_w [N_INTEG];
  logic [N_INTEG-1:0] conv_vec;

  dis_conv_edge u_edge (
    .clk_i, .rst_ni, .conv_i,
    .level_o(level_w), .edge_o(edge_w)
  );

  dis_seq_core #(.N_IN(N_IN), .CONV_CYCLES(CONV_CYCLES)) u_core (
    .clk_i, .rst_ni,
    .edge_i(edge_w), .level_i(level_w),
    .started_o(started_w), .int_side_o(int_side_w), .conv_side_o(conv_side_w),
    .busy_o(busy_w), .cur_in_o(cur_in_w), .done_o,
    .data_valid_no, .overrun_o
  );

  dis_cfg_capture #(.RANGE_W(RANGE_W)) u_cap (
    .clk_i, .rst_ni,
    .edge_i(edge_w), .level_i(level_w),
    .range_i, .test_i, .range_o, .test_sel_o
  );

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    for (genvar gs = 0; gs < 2; gs++) begin : g_side
      localparam int unsigned IDX = 2 * gi + gs;
      dis_integ_ctrl #(.IN_IDX(gi), .SIDE(gs[0]), .IN_W(IN_W)) u_ctl (
        .started_i(started_w), .int_side_i(int_side_w),
        .busy_i(busy_w), .cur_in_i(cur_in_w), .cfg_o(cfg_w[IDX])
      );
      assign sw_cfg_o[2*IDX +: 2] = cfg_w[IDX];
      assign conv_vec[IDX]        = (cfg_w[IDX] == CFG_CONV);

      AST_INTEG_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_w && int_side_w == gs[0]) |-> cfg_w[IDX] == CFG_INTEG); // R2
    end
  end

  assign busy_o    = busy_w;
  assign side_o    = int_side_w;
  assign mux_sel_o = {cur_in_w, conv_side_w};

  AST_ONE_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(conv_vec)); // R3
  AST_BUSY_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |-> $countones(conv_vec) == 1); // R4
endmodule

// File: tb/sim_dual_integ_seq.sv
`timescale 1ns/1ps
module sim_dual_integ_seq;
  localparam int C = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_ni, conv_i, test_i;
  logic [2:0] range_i, range_o;
  logic [7:0] sw_cfg_o;
  logic [1:0] mux_sel_o, done_o, test_sel_o;
  logic       busy_o, data_valid_no, overrun_o, side_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  dual_integ_seq #(.N_IN(2), .CONV_CYCLES(C), .RANGE_W(3)) u0 (
    .clk_i(clk), .rst_ni, .conv_i, .range_i, .test_i,
    .sw_cfg_o, .mux_sel_o, .busy_o, .done_o, .data_valid_no,
    .overrun_o, .side_o, .range_o, .test_sel_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  // code per integrator ii = 2*input + side after e edges of a cycle
  function automatic logic [1:0] exp_cfg(int ii, bit v, int e);
    int inp = ii / 2;
    int sd  = ii % 2;
    int isd = v ? 0 : 1;
    int cur = e / C;
    if (sd == isd) return 2'd2;
    if (e < 2*C && cur == inp) return 2'd3;
    if (e < 2*C && cur < inp) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check_step(bit v, int e, logic [2:0] rng, bit tst, bit ovr);
    string ph = (e < C) ? "R3" : (e < 2*C) ? "R4" : "R6";
    chk("R2 side", side_o, v ? 0 : 1);
    for (int ii = 0; ii < 4; ii++)
      chk({ph, " cfg"}, sw_cfg_o[2*ii +: 2], exp_cfg(ii, v, e));
    chk("R5 busy", busy_o, (e < 2*C) ? 1 : 0);
    if (e < 2*C) chk({ph, " mux"}, mux_sel_o, {e >= C, ~v ? 1'b0 : 1'b1});
    chk("R5 done", done_o, (e == C) ? 2'b01 : (e == 2*C) ? 2'b10 : 2'b00);
    chk((e >= 2*C) ? "R6 dvalid" : "R7 dvalid", data_valid_no, (e >= 2*C) ? 0 : 1);
    chk("R8 range", range_o, rng);
    chk("R9 test", test_sel_o, tst ? (v ? 2'b01 : 2'b10) : 2'b00);
    chk("R10 overrun", overrun_o, ovr);
  endtask

  task automatic run(bit v, logic [2:0] rng, bit tst, bit ovr, int len, bit wiggle);
    @(negedge clk);
    conv_i = v; range_i = rng; test_i = tst;
    @(negedge clk);
    for (int t = 2; t <= len; t++) begin
      @(negedge clk);
      check_step(v, t - 2, rng, tst, ovr);
      if (wiggle && t == C) begin
        range_i = ~rng;
        test_i  = ~tst;
      end
    end
  endtask

  initial begin
    rst_ni = 1'b0; conv_i = 1'b0; range_i = 3'd5; test_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cfg rst", sw_cfg_o, 0);
    chk("R1 dv rst", data_valid_no, 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cfg", sw_cfg_o, 0);
    chk("R1 dv", data_valid_no, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 ovr", overrun_o, 0);
    chk("R1 range", range_o, 0);
    chk("R1 test", test_sel_o, 0);
    // full sweep: all range codes, test on/off, alternating sides
    for (int i = 0; i < 16; i++)
      run((i % 2) == 0, 3'(i % 8), (i / 8) == 1, 1'b0, 2*C + 4, 1'b0);
    // early change mid-conversion: overrun
    run(1'b1, 3'd2, 1'b0, 1'b0, 5, 1'b0);
    run(1'b0, 3'd6, 1'b1, 1'b1, 2*C + 4, 1'b0);
    // inputs move between changes; outputs hold
    run(1'b1, 3'd3, 1'b1, 1'b1, 2*C + 4, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule